// File: doc/BRIEF.md
# BIST Link Error Monitor

This block sits on the receive side of a serial video link and checks it during built-in self-test. While the test mode flag is set, the far end transmits a constant all-zeroes payload. Once the forward link reports lock, every recovered word marked valid is compared with zero. Each word that carries any set bit is counted as an error in a saturating register, and a live pass output drops for a programmable number of cycles after each error.

The same block also tracks CRC failures reported for the back channel. It keeps two saturating 8-bit counters. The functional counter counts in every mode and restarts from zero when a test run begins. The test counter counts only during a run, and keeps its final value after the run ends so it can be read later. A drop of forward lock during a run sets a sticky flag. Checking pauses while lock is absent and resumes with the counts kept when lock returns.

A run begins on the first sampled cycle in which the mode flag is high after a cycle in which it was low. All inputs are sampled on the rising clock edge, and every output is registered.

Top module: `bist_link_monitor`

## Requirements
- R1: After reset, `fwdErrCount`, `crcFuncCount` and `crcBistCount` are 0, `passOut` is 1 and `lockLost` is 0.
- R2: A cycle with `bistMode`=1, `linkLock`=1, `dataValid`=1 and a nonzero `dataIn` increments `fwdErrCount` by one after that edge. A zero word leaves the count unchanged.
- R3: A word is ignored and leaves `fwdErrCount` and `passOut` untouched when `linkLock`=0, `bistMode`=0 or `dataValid`=0 in its cycle.
- R4: Each forward error drives `passOut` low for exactly PASS_HOLD cycles, starting with the cycle after the error. A new error during that window restarts the window. Otherwise `passOut` is 1.
- R5: All three counters saturate at 2^CNT_W-1 (255 by default) and do not wrap.
- R6: A cycle with `crcErrPulse`=1 and `backLinkDet`=1 increments `crcFuncCount` whatever the value of `bistMode`. Pulses while `backLinkDet`=0 are not counted by either counter.
- R7: A run start clears `fwdErrCount`, `crcFuncCount`, `crcBistCount` and `lockLost`. A run start is a cycle with `bistMode`=1 after a sampled cycle with `bistMode`=0, or after reset. Events in the run-start cycle are counted from zero.
- R8: `crcBistCount` increments on `crcErrPulse`=1 with `backLinkDet`=1 only while `bistMode`=1. After `bistMode` falls it holds its value until `swClear` or the next run start.
- R9: During a run, `linkLock` going from 1 to 0 sets `lockLost` after that edge, and it stays set until `swClear` or the next run start. The counts are kept across the loss of lock, and comparison resumes when lock returns.
- R10: `swClear`=1 clears `fwdErrCount`, both CRC counters and `lockLost`. Events in the same cycle are counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | DATA_W | Recovered forward-channel word |
| dataValid | input | 1 | `dataIn` holds a word this cycle |
| linkLock | input | 1 | Forward link locked |
| bistMode | input | 1 | Self-test mode active |
| backLinkDet | input | 1 | Back-channel link detected |
| crcErrPulse | input | 1 | One back-channel frame failed CRC this cycle |
| swClear | input | 1 | Software clear of counts and flag |
| fwdErrCount | output | CNT_W | Saturating forward error count |
| passOut | output | 1 | 1 = no recent error, 0 = error seen in the last PASS_HOLD cycles |
| lockLost | output | 1 | Sticky flag: lock fell during the current run |
| crcFuncCount | output | CNT_W | Functional-mode back-channel CRC error count |
| crcBistCount | output | CNT_W | Test-mode back-channel CRC error count |

## Verification
The properties take it as given that `crcErrPulse` is at most one event per cycle, that `bistMode` and `linkLock` are synchronous to `clk`, and that PASS_HOLD is at least one. The stimulus changes inputs only on the falling edge. It drives lock drops and restorals, clears and mode changes as single-cycle transitions, and pushes each counter past its limit to cover saturation. For every cycle it drives, the stimulus computes the expected register state from the requirements.

// File: rtl/bist_mon_pkg.sv
package bist_mon_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrRun;    // run start or software clear
    logic fwdErr;    // qualified nonzero word
    logic funcInc;   // back-channel CRC error, any mode
    logic bistInc;   // back-channel CRC error during a run
    logic lockDrop;  // lock fell during a run
  } monStrobe_t;

  localparam int NUM_CNT = 3;
  localparam int IDX_FWD  = 0;
  localparam int IDX_FUNC = 1;
  localparam int IDX_BIST = 2;
endpackage

// File: rtl/bist_sat_cnt.sv
module bist_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    base = clr ? '0 : count;
    nextCount = base;
    if (inc && (base != MAXV)) nextCount = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end
endmodule

// File: rtl/bist_mon_ctrl.sv
module bist_mon_ctrl
  import bist_mon_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic              linkLock,
  input  logic              bistMode,
  input  logic              backLinkDet,
  input  logic              crcErrPulse,
  input  logic              swClear,
  output monStrobe_t        strobe
);
  logic bistQ;
  logic lockQ;
  logic runStart;
  logic wordBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bistQ <= 1'b0;
      lockQ <= 1'b0;
    end else begin
      bistQ <= bistMode;
      lockQ <= linkLock;
    end
  end

  always_comb begin
    runStart = bistMode && !bistQ;
    wordBad  = |dataIn;
    strobe.clrRun   = runStart || swClear;
    strobe.fwdErr   = bistMode && linkLock && dataValid && wordBad;
    strobe.funcInc  = crcErrPulse && backLinkDet;
    strobe.bistInc  = crcErrPulse && backLinkDet && bistMode;
    strobe.lockDrop = bistMode && lockQ && !linkLock;
  end
endmodule

// File: rtl/bist_mon_dpath.sv
module bist_mon_dpath
  import bist_mon_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PASS_HOLD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  monStrobe_t       strobe,
  output logic [CNT_W-1:0] fwdErrCount,
  output logic [CNT_W-1:0] crcFuncCount,
  output logic [CNT_W-1:0] crcBistCount,
  output logic             passOut,
  output logic             lockLost
);
  localparam int TW = $clog2(PASS_HOLD + 1);
  localparam logic [TW-1:0] HOLD_V = TW'(PASS_HOLD);

  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cntArr [NUM_CNT];
  logic [TW-1:0]      holdTimer;

  always_comb begin
    incVec = '0;
    incVec[IDX_FWD]  = strobe.fwdErr;
    incVec[IDX_FUNC] = strobe.funcInc;
    incVec[IDX_BIST] = strobe.bistInc;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    bist_sat_cnt #(.CNT_W(CNT_W)) uCnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clrRun),
      .inc   (incVec[i]),
      .count (cntArr[i])
    );
  end

  assign fwdErrCount  = cntArr[IDX_FWD];
  assign crcFuncCount = cntArr[IDX_FUNC];
  assign crcBistCount = cntArr[IDX_BIST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdTimer <= '0;
    else if (strobe.fwdErr)      holdTimer <= HOLD_V;
    else if (holdTimer != '0)    holdTimer <= holdTimer - 1'b1;
  end

  assign passOut = (holdTimer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockLost <= 1'b0;
    else       lockLost <= strobe.lockDrop || (lockLost && !strobe.clrRun);
  end
endmodule

// File: rtl/bist_link_monitor.sv
module bist_link_monitor
  import bist_mon_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int CNT_W     = 8,
  parameter int PASS_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic              linkLock,
  input  logic              bistMode,
  input  logic              backLinkDet,
  input  logic              crcErrPulse,
  input  logic              swClear,
  output logic [CNT_W-1:0]  fwdErrCount,
  output logic              passOut,
  output logic              lockLost,
  output logic [CNT_W-1:0]  crcFuncCount,
  output logic [CNT_W-1:0]  crcBistCount
);
  monStrobe_t strobe;

  bist_mon_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .dataValid   (dataValid),
    .linkLock    (linkLock),
    .bistMode    (bistMode),
    .backLinkDet (backLinkDet),
    .crcErrPulse (crcErrPulse),
    .swClear     (swClear),
    .strobe      (strobe)
  );

  bist_mon_dpath #(.CNT_W(CNT_W), .PASS_HOLD(PASS_HOLD)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fwdErrCount  (fwdErrCount),
    .crcFuncCount (crcFuncCount),
    .crcBistCount (crcBistCount),
    .passOut      (passOut),
    .lockLost     (lockLost)
  );
endmodule

// File: rtl/bist_mon_chk.sv
module bist_mon_chk #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dataIn,
  input logic              dataValid,
  input logic              linkLock,
  input logic              bistMode,
  input logic              backLinkDet,
  input logic              crcErrPulse,
  input logic              swClear,
  input logic [CNT_W-1:0]  fwdErrCount,
  input logic              passOut,
  input logic              lockLost,
  input logic [CNT_W-1:0]  crcFuncCount,
  input logic [CNT_W-1:0]  crcBistCount
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic modeSeen;
  logic anyClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeSeen <= 1'b0;
    else       modeSeen <= bistMode;
  end

  assign anyClr = swClear || (bistMode && !modeSeen);

  // R3
  ignored_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyClr && !(bistMode && linkLock && dataValid)) |=> $stable(fwdErrCount));

  // R2
  bad_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyClr && bistMode && linkLock && dataValid && (dataIn != '0) && fwdErrCount != TOP)
      |=> fwdErrCount == $past(fwdErrCount) + 1'b1);

  // R4
  pass_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bistMode && linkLock && dataValid && (dataIn != '0)) |=> !passOut);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyClr && crcFuncCount == TOP) |=> crcFuncCount == TOP);

  // R6
  func_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyClr && crcErrPulse && backLinkDet && crcFuncCount != TOP)
      |=> crcFuncCount == $past(crcFuncCount) + 1'b1);

  // R8
  bist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bistMode && !swClear) |=> $stable(crcBistCount));

  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bistMode && !modeSeen && !crcErrPulse) |=> (crcBistCount == '0 && crcFuncCount == '0));

  // R9
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockLost && !anyClr) |=> lockLost);
endmodule

bind bist_link_monitor bist_mon_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .dataIn       (dataIn),
  .dataValid    (dataValid),
  .linkLock     (linkLock),
  .bistMode     (bistMode),
  .backLinkDet  (backLinkDet),
  .crcErrPulse  (crcErrPulse),
  .swClear      (swClear),
  .fwdErrCount  (fwdErrCount),
  .passOut      (passOut),
  .lockLost     (lockLost),
  .crcFuncCount (crcFuncCount),
  .crcBistCount (crcBistCount)
);

// File: tb/sim_bist_link_monitor.sv
`timescale 1ns/1ps
module sim_bist_link_monitor;
  localparam int DATA_W = 24;
  localparam int CNT_W  = 8;
  localparam int HOLD   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic dataValid = 1'b0, linkLock = 1'b0, bistMode = 1'b0;
  logic backLinkDet = 1'b0, crcErrPulse = 1'b0, swClear = 1'b0;
  logic [CNT_W-1:0] fwdErrCount, crcFuncCount, crcBistCount;
  logic passOut, lockLost;

  always #2 clk = ~clk;

  bist_link_monitor #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PASS_HOLD(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid),
    .linkLock(linkLock), .bistMode(bistMode), .backLinkDet(backLinkDet),
    .crcErrPulse(crcErrPulse), .swClear(swClear),
    .fwdErrCount(fwdErrCount), .passOut(passOut), .lockLost(lockLost),
    .crcFuncCount(crcFuncCount), .crcBistCount(crcBistCount)
  );

  typedef struct {
    int    e, f, b;
    bit    p, l;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];
  int total = 0;
  int bad = 0;

  // reference state
  int  mErr = 0, mFunc = 0, mBist = 0, mTimer = 0;
  bit  mLost = 0, mPrevBist = 0, mPrevLock = 0;

  function automatic int satAdd(int v, bit inc);
    if (inc && v < 255) return v + 1;
    return v;
  endfunction

  task automatic step(input bit bm, input bit lk, input bit vl,
                      input logic [DATA_W-1:0] d, input bit bld,
                      input bit crc, input bit sw, input string tag);
    bit clr, fwd;
    expItem_t it;
    @(negedge clk);
    bistMode = bm; linkLock = lk; dataValid = vl; dataIn = d;
    backLinkDet = bld; crcErrPulse = crc; swClear = sw;
    clr = (bm && !mPrevBist) || sw;
    fwd = bm && lk && vl && (d != '0);
    mErr  = satAdd(clr ? 0 : mErr, fwd);
    mFunc = satAdd(clr ? 0 : mFunc, crc && bld);
    mBist = satAdd(clr ? 0 : mBist, crc && bld && bm);
    mLost = (bm && mPrevLock && !lk) || (mLost && !clr);
    if (fwd) mTimer = HOLD;
    else if (mTimer > 0) mTimer = mTimer - 1;
    mPrevBist = bm; mPrevLock = lk;
    it.e = mErr; it.f = mFunc; it.b = mBist;
    it.p = (mTimer == 0); it.l = mLost; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic cmp(input int act, input int exp, input string what, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        cmp(int'(fwdErrCount),  it.e, "fwdErrCount",  it.tag);
        cmp(int'(crcFuncCount), it.f, "crcFuncCount", it.tag);
        cmp(int'(crcBistCount), it.b, "crcBistCount", it.tag);
        cmp(int'(passOut),      int'(it.p), "passOut",  it.tag);
        cmp(int'(lockLost),     int'(it.l), "lockLost", it.tag);
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (fwdErrCount != 0 || crcFuncCount != 0 || crcBistCount != 0 || passOut != 1 || lockLost != 0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%0d/%0d/%0d/%0b/%0b expected=0/0/0/1/0",
               fwdErrCount, crcFuncCount, crcBistCount, passOut, lockLost);
    end
    rstN = 1'b1;
    step(0, 0, 0, '0, 0, 0, 0, "R1");
    // R3: words outside the test mode are ignored
    step(0, 1, 1, 24'hFFFFFF, 0, 0, 0, "R3");
    // R6: functional CRC count outside the test mode, and ignored without link detect
    step(0, 1, 0, '0, 1, 1, 0, "R6");
    step(0, 1, 0, '0, 1, 1, 0, "R6");
    step(0, 1, 0, '0, 0, 1, 0, "R6");
    // R7: run start clears the functional count, the same-cycle pulse counts from zero
    step(1, 0, 1, 24'h000100, 1, 1, 0, "R7");
    // R3: words before lock and words without valid are ignored
    step(1, 0, 1, 24'h800000, 1, 0, 0, "R3");
    step(1, 1, 0, 24'h000001, 1, 0, 0, "R3");
    // R2: zero words pass, nonzero words count
    step(1, 1, 1, '0, 1, 0, 0, "R2");
    step(1, 1, 1, 24'h000001, 1, 0, 0, "R2");
    for (int i = 0; i < HOLD + 1; i++) step(1, 1, 1, '0, 1, 0, 0, "R4");
    // R4: retrigger during hold
    step(1, 1, 1, 24'h010000, 1, 0, 0, "R4");
    step(1, 1, 1, '0, 1, 0, 0, "R4");
    step(1, 1, 1, 24'h000020, 1, 0, 0, "R4");
    for (int i = 0; i < HOLD + 1; i++) step(1, 1, 1, '0, 1, 0, 0, "R4");
    // R8: test CRC counter in the run
    step(1, 1, 1, '0, 1, 1, 0, "R8");
    step(1, 1, 1, '0, 1, 1, 0, "R8");
    step(1, 1, 1, '0, 0, 1, 0, "R8");
    // R9: lock drop during the run
    step(1, 0, 1, 24'hFFFFFF, 1, 0, 0, "R9");
    step(1, 0, 1, 24'h000004, 1, 1, 0, "R9");
    step(1, 1, 1, 24'h000004, 1, 0, 0, "R9");
    step(1, 1, 1, '0, 1, 0, 0, "R9");
    // R8: exit holds the test counter, functional keeps counting
    step(0, 1, 1, 24'h000004, 1, 1, 0, "R8");
    step(0, 1, 0, '0, 1, 1, 0, "R8");
    for (int i = 0; i < HOLD; i++) step(0, 1, 0, '0, 1, 0, 0, "R8");
    // R10: software clear with a same-cycle pulse
    step(0, 1, 0, '0, 1, 1, 1, "R10");
    step(0, 1, 0, '0, 1, 0, 0, "R10");
    // R5: saturation of all counters
    step(1, 1, 1, 24'h000001, 1, 1, 0, "R5");
    for (int i = 0; i < 270; i++) step(1, 1, 1, 24'h000003, 1, 1, 0, "R5");
    step(1, 0, 1, '0, 1, 0, 0, "R5");
    step(1, 1, 1, '0, 1, 0, 0, "R5");
    // R7: second run start clears everything including the sticky flag
    step(0, 1, 0, '0, 1, 0, 0, "R7");
    step(1, 1, 1, '0, 1, 0, 0, "R7");
    step(1, 1, 1, '0, 1, 0, 0, "R7");
    // R10: clear during a run
    step(1, 1, 1, 24'h000001, 1, 1, 0, "R10");
    step(1, 1, 1, '0, 1, 0, 1, "R10");
    step(1, 1, 1, '0, 1, 0, 0, "R10");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule